// File: doc/BRIEF.md
# Management Configuration Register with Self-Clearing Soft Reset

This block is a single 32-bit control word that sits on a request/acknowledge management bus. It holds the options used by neighbouring Ethernet, framing and link-start logic, and drives each of them out as a decoded field. Two of these fields are 4-bit byte counts. Writes that would put either count outside its legal range leave that count alone. All other parts of the same word are still written.

Bit 31 starts a soft reset of the surrounding core. Once it is written with 1, the `core_rst` output is raised and bit 31 reads back as 1. Both stay that way until the clock-ok status input has been seen low and then high again. The soft reset never touches the register's own settings. Only the power-on reset `rst_n` restores the defaults.

Top module: `mgmt_cfg_reg`

## Requirements
- R1: After `rst_n` the word reads 0x15CF0000. This means gmii_8bit (bit 28) = 1, jam count (27:24) = 5, gap count (23:20) = 12, bits 19..16 = 1, and bits 31, 15, 8, 2 and 0 = 0. `ack` and `core_rst` are low.
- R2: `ack` rises in the cycle after `req` is first sampled high. It stays high for exactly one cycle, and it does not rise again until `req` has been sampled low.
- R3: A write (`req` with `wr`=1) updates bits 28, 19..15, 8, 2 and 0 from `wdata`. Reserved bits 30:29, 14:9, 7:3 and 1 always read 0.
- R4: The jam count (bits 27:24) takes a new value only if that value is in 1..15. A write of 0 leaves it unchanged.
- R5: The gap count (bits 23:20) takes a new value only if that value is in 3..15. A write of 0..2 leaves it unchanged.
- R6: Writing 1 to bit 31 raises `core_rst`, and bit 31 then reads 1, from the cycle after the write is acknowledged.
- R7: `core_rst` and bit 31 stay high until `clk_ok` has been sampled low and then sampled high. They clear one cycle after that high sample.
- R8: While a soft reset runs, and after it ends, every other field keeps its value unless it is explicitly written.
- R9: Writing 0 to bit 31 while a soft reset runs does not end that reset.
- R10: A read (`req` with `wr`=0) changes no state.
- R11: Each decoded output equals the field it comes from in the readback word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| req | input | 1 | Management request |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Current register value |
| ack | output | 1 | One-cycle acknowledge |
| clk_ok | input | 1 | Clock-ok status used to end a soft reset |
| core_rst | output | 1 | Core reset request |
| gmii_8bit | output | 1 | Bit 28: 8-bit versus 4-bit media data |
| jam_cnt | output | 4 | Bits 27:24: jam byte count |
| gap_cnt | output | 4 | Bits 23:20: interframe gap byte count |
| tx_ign_rxdv | output | 1 | Bit 19: collision ignores receive-valid |
| rx_ign_txen | output | 1 | Bit 18: receiver ignores transmitter |
| cm_gap_en | output | 1 | Bit 17: insert gaps on the control channel |
| hdlc_pace | output | 1 | Bit 16: pace HDLC strobes evenly |
| hdr_swap | output | 1 | Bit 15: reverse 2-bit sync headers |
| slave_tx_early | output | 1 | Bit 8: slave transmits before sync |
| sap_defect | output | 1 | Bit 2: access-point defect indicator |
| link_rst_bit | output | 1 | Bit 0: reset bit to send on the link |

## Verification
The hardest situation to reach is a soft reset that is still running when new writes arrive. Those writes must update the fields but must not clear bit 31. The completion must also depend on the low-then-high sequence of `clk_ok`, not on its level alone. The bench holds `clk_ok` high across several cycles and across a write of 0 to bit 31, which shows that neither of these ends the reset. It then pulses `clk_ok` low for one cycle and checks that the reset clears exactly one cycle after `clk_ok` returns high. A full sweep of all 256 jam and gap pairs covers the range guards.

// File: rtl/mgmt_cfg_reg.sv
module mgmt_cfg_reg #(
  parameter logic [3:0] JAM_RST = 4'd5,
  parameter logic [3:0] GAP_RST = 4'd12,
  parameter logic [3:0] JAM_MIN = 4'd1,
  parameter logic [3:0] GAP_MIN = 4'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ack,
  input  logic        clk_ok,
  output logic        core_rst,
  output logic        gmii_8bit,
  output logic [3:0]  jam_cnt,
  output logic [3:0]  gap_cnt,
  output logic        tx_ign_rxdv,
  output logic        rx_ign_txen,
  output logic        cm_gap_en,
  output logic        hdlc_pace,
  output logic        hdr_swap,
  output logic        slave_tx_early,
  output logic        sap_defect,
  output logic        link_rst_bit
);

  logic served, busy, saw_low;
  logic wr_hit;
  logic unused_bits;

  assign wr_hit      = req & ~served & wr;
  assign unused_bits = ^{wdata[30:29], wdata[14:9], wdata[7:3], wdata[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack            <= 1'b0;
      served         <= 1'b0;
      busy           <= 1'b0;
      saw_low        <= 1'b0;
      gmii_8bit      <= 1'b1;
      jam_cnt        <= JAM_RST;
      gap_cnt        <= GAP_RST;
      tx_ign_rxdv    <= 1'b1;
      rx_ign_txen    <= 1'b1;
      cm_gap_en      <= 1'b1;
      hdlc_pace      <= 1'b1;
      hdr_swap       <= 1'b0;
      slave_tx_early <= 1'b0;
      sap_defect     <= 1'b0;
      link_rst_bit   <= 1'b0;
    end else begin
      ack    <= req & ~served;
      served <= req;
      if (wr_hit) begin
        gmii_8bit      <= wdata[28];
        tx_ign_rxdv    <= wdata[19];
        rx_ign_txen    <= wdata[18];
        cm_gap_en      <= wdata[17];
        hdlc_pace      <= wdata[16];
        hdr_swap       <= wdata[15];
        slave_tx_early <= wdata[8];
        sap_defect     <= wdata[2];
        link_rst_bit   <= wdata[0];
        if (wdata[27:24] >= JAM_MIN) jam_cnt <= wdata[27:24];
        if (wdata[23:20] >= GAP_MIN) gap_cnt <= wdata[23:20];
      end
      if (wr_hit && wdata[31]) begin
        busy    <= 1'b1;
        saw_low <= 1'b0;
      end else if (busy) begin
        if (!clk_ok)      saw_low <= 1'b1;
        else if (saw_low) busy    <= 1'b0;
      end
    end
  end

  assign core_rst = busy;

  assign rdata = {busy, 2'b00, gmii_8bit, jam_cnt, gap_cnt,
                  tx_ign_rxdv, rx_ign_txen, cm_gap_en, hdlc_pace, hdr_swap,
                  6'b0, slave_tx_early, 5'b0, sap_defect, 1'b0, link_rst_bit};

endmodule

// File: rtl/mgmt_cfg_reg_chk.sv
module mgmt_cfg_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       wr,
  input logic       wbit31,
  input logic       ack,
  input logic       clk_ok,
  input logic       core_rst,
  input logic [3:0] jam_cnt,
  input logic [3:0] gap_cnt,
  input logic       gmii_8bit
);

  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req));

  a_r4_jam_legal: assert property (@(posedge clk) disable iff (!rst_n)
    jam_cnt != 4'd0);

  a_r5_gap_legal: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt >= 4'd3);

  a_r6_rst_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> ack && $past(req && wr && wbit31));

  a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && !clk_ok) |=> core_rst);

  a_r7_end_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> $past(clk_ok));

  a_r8_gap_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gap_cnt) |-> ack && $past(wr));

  a_r8_gmii_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gmii_8bit) |-> ack && $past(wr));

endmodule

bind mgmt_cfg_reg mgmt_cfg_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .wbit31(wdata[31]),
  .ack(ack), .clk_ok(clk_ok), .core_rst(core_rst),
  .jam_cnt(jam_cnt), .gap_cnt(gap_cnt), .gmii_8bit(gmii_8bit)
);

// File: tb/mgmt_cfg_reg_bench.sv
module mgmt_cfg_reg_bench;
  localparam time CLK_PER = 10ns;
  localparam logic [31:0] BIT_MASK = 32'h100F8105;
  localparam logic [31:0] SRST     = 32'h80000000;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0, clk_ok = 1'b1;
  logic [31:0] wdata = '0, rdata;
  logic ack, core_rst, gmii_8bit, tx_ign_rxdv, rx_ign_txen, cm_gap_en;
  logic hdlc_pace, hdr_swap, slave_tx_early, sap_defect, link_rst_bit;
  logic [3:0] jam_cnt, gap_cnt;
  int total = 0, bad = 0;
  logic [31:0] model;

  always #(CLK_PER/2) clk = ~clk;

  mgmt_cfg_reg u_mgmt_cfg_reg (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .wdata(wdata), .rdata(rdata),
    .ack(ack), .clk_ok(clk_ok), .core_rst(core_rst), .gmii_8bit(gmii_8bit),
    .jam_cnt(jam_cnt), .gap_cnt(gap_cnt), .tx_ign_rxdv(tx_ign_rxdv),
    .rx_ign_txen(rx_ign_txen), .cm_gap_en(cm_gap_en), .hdlc_pace(hdlc_pace),
    .hdr_swap(hdr_swap), .slave_tx_early(slave_tx_early),
    .sap_defect(sap_defect), .link_rst_bit(link_rst_bit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] upd(input logic [31:0] old, input logic [31:0] w);
    logic [31:0] n;
    n = (old & ~BIT_MASK) | (w & BIT_MASK);
    if (w[27:24] != 4'd0) n[27:24] = w[27:24];
    if (w[23:20] >= 4'd3) n[23:20] = w[23:20];
    return n;
  endfunction

  task automatic access(input logic w, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = w; wdata = d;
    @(negedge clk);
    chk("R2 ack high", {31'b0, ack}, 32'd1);
    req = 1'b0; wr = 1'b0;
    @(negedge clk);
    chk("R2 ack low", {31'b0, ack}, 32'd0);
  endtask

  task automatic chk_outs(input logic [31:0] m);
    chk("R11 decoded", {gmii_8bit, jam_cnt, gap_cnt, tx_ign_rxdv, rx_ign_txen,
        cm_gap_en, hdlc_pace, hdr_swap, slave_tx_early, sap_defect, link_rst_bit},
        {m[28], m[27:24], m[23:20], m[19:15], m[8], m[2], m[0]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int acks;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model = 32'h15CF0000;
    chk("R1 reset word", rdata, model);
    chk("R1 ack/core_rst", {30'b0, ack, core_rst}, 32'd0);
    chk_outs(model);

    // R2: long request gives one ack
    @(negedge clk); req = 1'b1; wr = 1'b0; acks = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); acks += int'(ack); end
    req = 1'b0; @(negedge clk);
    chk("R2 one ack per request", acks, 1);

    // R3: reserved bits only, then all ones
    access(1'b1, 32'h60007EFA); model = upd(model, 32'h60007EFA);
    chk("R3 reserved read 0", rdata, model);
    access(1'b1, 32'h7FFFFFFF); model = upd(model, 32'h7FFFFFFF);
    chk("R3 all writable", rdata, model);

    // R10: read with junk data
    access(1'b0, 32'hFFFFFFFF);
    chk("R10 read no effect", rdata, model);

    // R4 R5 R11: exhaustive count sweep
    for (int j = 0; j < 16; j++)
      for (int g = 0; g < 16; g++) begin
        logic [31:0] w;
        w = (32'(j) << 24) | (32'(g) << 20) | (((j ^ g) & 1) != 0 ? BIT_MASK : 32'h0);
        access(1'b1, w); model = upd(model, w);
        chk("R4 R5 sweep word", rdata, model);
        chk_outs(model);
      end

    // R6 R7 R8 R9: soft reset
    access(1'b1, model | SRST);
    chk("R6 core_rst set", {31'b0, core_rst}, 32'd1);
    chk("R6 R8 readback busy", rdata, model | SRST);
    repeat (4) @(negedge clk);
    chk("R7 held while clk_ok high", {31'b0, core_rst}, 32'd1);
    access(1'b1, 32'h04500004); model = upd(model, 32'h04500004);
    chk("R9 write 0 keeps reset", rdata, model | SRST);
    chk_outs(model);
    clk_ok = 1'b0;
    @(negedge clk);
    chk("R7 held while clk_ok low", {31'b0, core_rst}, 32'd1);
    clk_ok = 1'b1;
    @(negedge clk);
    chk("R7 cleared after low-high", {31'b0, core_rst}, 32'd0);
    chk("R8 fields kept", rdata, model);

    // restart when clk_ok already low
    clk_ok = 1'b0;
    access(1'b1, model | SRST);
    chk("R6 restart", rdata, model | SRST);
    clk_ok = 1'b1;
    @(negedge clk);
    chk("R7 second clear", {31'b0, core_rst}, 32'd0);
    chk("R8 fields kept 2", rdata, model);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule